// File: doc/BRIEF.md
# USB 2.0 Host Event Status Register

This block keeps the event-reporting status word of a USB 2.0 host controller and the logic that raises its bits. Three bits are set by hardware events: a host system error bit, raised when a memory read issued by the controller completes with a status other than successful; a frame list rollover bit, raised each time bit 13 of the frame index counter changes; and a port change detect bit, raised from per-port change indications of ports that this controller owns. Software clears any of these bits by writing a one to it through a plain register write port.

The block also drives a one-cycle request to clear the Run/Stop bit of the command register whenever a host system error is taken, so that no further scheduled transfers run. A single interrupt output is the registered OR of each event bit gated by its enable bit. On a return from a low-power state to the active state, a wake pulse reloads the port change detect bit with the OR of every per-port change indication. The schedule engine, the port state machines and the bus interface sit outside this block. They appear here only as plain level inputs, and since none of them carries a data stream, every pin is a plain control or status signal with no valid/ready handshake.

Top module: `usb_host_event_status`

## Requirements
- R1: After reset the status word reads 0x00001000, and irq and run_stop_clr are 0.
- R2: A cycle with rd_cmp_valid=1 and rd_cmp_ok=0 sets status bit 4 at the next clock edge. A completion with rd_cmp_ok=1 leaves bit 4 unchanged.
- R3: run_stop_clr is 1 in exactly the cycle after each clock edge that takes a failed read completion, and 0 otherwise. While it is 1, status bit 4 is 1.
- R4: A write with wr_en=1 clears each of status bits 4, 3 and 2 whose wr_data bit is 1. Bits written with 0 keep their value, and every other status bit keeps its reset value.
- R5: When a set event and a write-one clear reach the same bit at the same clock edge, the bit ends up 1.
- R6: Status bit 3 is set at the clock edge after bit 13 of frame_idx changes, for a change from 0 to 1 and for a change from 1 to 0. Changes in the other frame_idx bits do not set it.
- R7: Status bit 2 is set at the clock edge after a 0-to-1 edge on any of a port's change inputs (port_csc, port_pec, port_occ, port_fpr) while that port's port_owner is 0. A change input held high sets the bit only once.
- R8: Change edges on a port whose port_owner is 1 do not set status bit 2.
- R9: If port_owner of a connected port (port_conn=1) falls from 1 to 0, status bit 2 is set on the second clock edge after the fall while that port's port_csc is 1, even when port_csc saw no new edge.
- R10: A cycle with wake_load=1 loads status bit 2 with the OR of all change inputs of all ports, ignoring ownership. A load of 0 clears a bit that was set.
- R11: irq equals, one cycle later, the OR of (status bit 4 AND int_en[2]), (status bit 3 AND int_en[1]) and (status bit 2 AND int_en[0]).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_cmp_valid | input | 1 | A memory read issued by the controller completes this cycle |
| rd_cmp_ok | input | 1 | The completing read returned a successful status |
| frame_idx | input | FRAME_W | Frame index counter |
| port_owner | input | NPORTS | Per-port owner bit, 0 = owned by this controller |
| port_conn | input | NPORTS | Per-port current connect status |
| port_csc | input | NPORTS | Per-port connect status change |
| port_pec | input | NPORTS | Per-port enable change |
| port_occ | input | NPORTS | Per-port overcurrent change |
| port_fpr | input | NPORTS | Per-port force resume indication |
| wake_load | input | 1 | Return to the active power state, reloads bit 2 |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 32 | Write data, ones clear the matching event bits |
| int_en | input | 3 | Interrupt enables: [2] error, [1] rollover, [0] port change |
| status | output | 32 | Status word |
| run_stop_clr | output | 1 | One-cycle request to clear Run/Stop |
| irq | output | 1 | Registered interrupt output |

## Verification
The bench builds the block with NPORTS=3 instead of the default four, with the frame counter left at its default 14 bits. Three ports let one port stay owned while another is handed away, and leave the highest-numbered port to show that the per-port generate slices reach the last index. The 14-bit counter puts the rollover bit at the top of frame_idx, so both directions of its toggle are reached from 0x1FFF and 0x2000 without touching lower-bit behaviour.

// File: rtl/hce_pkg.sv
package hce_pkg;
  localparam int unsigned STAT_W   = 32;
  localparam logic [31:0] STAT_RST = 32'h0000_1000;
  localparam int unsigned POS_HSE  = 4;
  localparam int unsigned POS_FLR  = 3;
  localparam int unsigned POS_PCD  = 2;
  localparam int unsigned N_EVT    = 3;
  localparam int unsigned EV_PCD   = 0;
  localparam int unsigned EV_FLR   = 1;
  localparam int unsigned EV_HSE   = 2;
  localparam int unsigned N_CHG    = 4;
endpackage

// File: rtl/hce_w1c_bit.sv
module hce_w1c_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic load_en_i,
  input  logic load_val_i,
  output logic q_o
);
  logic q_n;

  // priority: hardware set, then reload, then software clear (R5)
  always_comb begin
    if (set_i)          q_n = 1'b1;
    else if (load_en_i) q_n = load_val_i;
    else if (clr_i)     q_n = 1'b0;
    else                q_n = q_o;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_n;
  end
endmodule

// File: rtl/hce_roll_watch.sv
module hce_roll_watch #(
  parameter int unsigned FRAME_W  = 14,
  parameter int unsigned ROLL_BIT = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] frame_idx,
  output logic               roll_evt
);
  logic roll_q;

  always_ff @(posedge clk) begin
    if (!rst_n) roll_q <= 1'b0;
    else        roll_q <= frame_idx[ROLL_BIT];
  end

  // either direction of the watched bit marks a wrap of the list (R6)
  assign roll_evt = frame_idx[ROLL_BIT] ^ roll_q;
endmodule

// File: rtl/hce_port_watch.sv
module hce_port_watch
  import hce_pkg::*;
#(
  parameter int unsigned NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] port_owner,
  input  logic [NPORTS-1:0] port_conn,
  input  logic [NPORTS-1:0] port_csc,
  input  logic [NPORTS-1:0] port_pec,
  input  logic [NPORTS-1:0] port_occ,
  input  logic [NPORTS-1:0] port_fpr,
  output logic              pcd_evt,
  output logic              any_chg
);
  localparam int unsigned CHG_W = NPORTS * N_CHG;

  logic [CHG_W-1:0]  chg_now;
  logic [CHG_W-1:0]  chg_q;
  logic [NPORTS-1:0] own_q;
  logic [NPORTS-1:0] arm_q;
  logic [NPORTS-1:0] arm_n;
  logic [NPORTS-1:0] edge_hit;
  logic [NPORTS-1:0] ho_fire;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [N_CHG-1:0] now_p;
    logic [N_CHG-1:0] old_p;
    assign now_p = {port_csc[p], port_pec[p], port_occ[p], port_fpr[p]};
    assign chg_now[p*N_CHG +: N_CHG] = now_p;
    assign old_p = chg_q[p*N_CHG +: N_CHG];

    // rising edge on any change input of an owned port (R7, R8)
    assign edge_hit[p] = ~port_owner[p] & (|(now_p & ~old_p));

    // handover of a connected port arms a level-sensitive report (R9)
    always_comb begin
      if (port_owner[p])
        arm_n[p] = 1'b0;
      else if (own_q[p] & port_conn[p])
        arm_n[p] = 1'b1;
      else if (ho_fire[p])
        arm_n[p] = 1'b0;
      else
        arm_n[p] = arm_q[p];
    end
    assign ho_fire[p] = arm_q[p] & ~port_owner[p] & port_csc[p];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chg_q <= '0;
      own_q <= '0;
      arm_q <= '0;
    end else begin
      chg_q <= chg_now;
      own_q <= port_owner;
      arm_q <= arm_n;
    end
  end

  assign pcd_evt = (|edge_hit) | (|ho_fire);
  assign any_chg = |chg_now;
endmodule

// File: rtl/usb_host_event_status.sv
module usb_host_event_status
  import hce_pkg::*;
#(
  parameter int unsigned NPORTS   = 4,
  parameter int unsigned FRAME_W  = 14,
  parameter int unsigned ROLL_BIT = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_cmp_valid,
  input  logic                rd_cmp_ok,
  input  logic [FRAME_W-1:0]  frame_idx,
  input  logic [NPORTS-1:0]   port_owner,
  input  logic [NPORTS-1:0]   port_conn,
  input  logic [NPORTS-1:0]   port_csc,
  input  logic [NPORTS-1:0]   port_pec,
  input  logic [NPORTS-1:0]   port_occ,
  input  logic [NPORTS-1:0]   port_fpr,
  input  logic                wake_load,
  input  logic                wr_en,
  input  logic [STAT_W-1:0]   wr_data,
  input  logic [N_EVT-1:0]    int_en,
  output logic [STAT_W-1:0]   status,
  output logic                run_stop_clr,
  output logic                irq
);
  localparam int unsigned EVT_POS [N_EVT] = '{POS_PCD, POS_FLR, POS_HSE};

  logic [N_EVT-1:0] set_v;
  logic [N_EVT-1:0] clr_v;
  logic [N_EVT-1:0] ld_en_v;
  logic [N_EVT-1:0] ld_val_v;
  logic [N_EVT-1:0] evt_q;
  logic             hse_evt;
  logic             roll_evt;
  logic             pcd_evt;
  logic             any_chg;

  assign hse_evt = rd_cmp_valid & ~rd_cmp_ok;  // R2

  hce_roll_watch #(.FRAME_W(FRAME_W), .ROLL_BIT(ROLL_BIT)) u_roll (
    .clk(clk), .rst_n(rst_n), .frame_idx(frame_idx), .roll_evt(roll_evt)
  );

  hce_port_watch #(.NPORTS(NPORTS)) u_ports (
    .clk(clk), .rst_n(rst_n),
    .port_owner(port_owner), .port_conn(port_conn),
    .port_csc(port_csc), .port_pec(port_pec),
    .port_occ(port_occ), .port_fpr(port_fpr),
    .pcd_evt(pcd_evt), .any_chg(any_chg)
  );

  assign set_v[EV_HSE] = hse_evt;
  assign set_v[EV_FLR] = roll_evt;
  assign set_v[EV_PCD] = pcd_evt;

  // only the port change bit can be reloaded on wake (R10)
  assign ld_en_v  = {1'b0, 1'b0, wake_load};
  assign ld_val_v = {1'b0, 1'b0, any_chg};

  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    assign clr_v[i] = wr_en & wr_data[EVT_POS[i]];  // R4
    hce_w1c_bit u_bit (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_v[i]), .clr_i(clr_v[i]),
      .load_en_i(ld_en_v[i]), .load_val_i(ld_val_v[i]),
      .q_o(evt_q[i])
    );
  end

  always_comb begin
    status = STAT_RST;
    for (int i = 0; i < N_EVT; i++) status[EVT_POS[i]] = evt_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_stop_clr <= 1'b0;
      irq          <= 1'b0;
    end else begin
      run_stop_clr <= hse_evt;              // R3
      irq          <= |(evt_q & int_en);    // R11
    end
  end
endmodule

// File: rtl/hce_status_chk.sv
module hce_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_cmp_valid,
  input logic        rd_cmp_ok,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [2:0]  int_en,
  input logic [31:0] status,
  input logic        run_stop_clr,
  input logic        irq
);
  assert_err_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmp_valid && !rd_cmp_ok) |=> status[4]);

  assert_rs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmp_valid && !rd_cmp_ok) |=> run_stop_clr);

  assert_rs_with_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_stop_clr |-> status[4]);

  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[4] && !(rd_cmp_valid && !rd_cmp_ok)) |=> !status[4]);

  assert_zero_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !(wr_en && wr_data[4])) |=> status[4]);

  assert_fixed_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status[31:5] == 27'h80) && (status[1:0] == 2'b00));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmp_valid && !rd_cmp_ok && wr_en && wr_data[4]) |=> status[4]);

  assert_irq_lag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past({status[4], status[3], status[2]}) & $past(int_en))));
endmodule

bind usb_host_event_status hce_status_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_cmp_valid(rd_cmp_valid), .rd_cmp_ok(rd_cmp_ok),
  .wr_en(wr_en), .wr_data(wr_data), .int_en(int_en),
  .status(status), .run_stop_clr(run_stop_clr), .irq(irq)
);

// File: tb/sim_usb_host_event_status.sv
module sim_usb_host_event_status;
  localparam int NP = 3;
  localparam int FW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_cmp_valid = 1'b0, rd_cmp_ok = 1'b0;
  logic [FW-1:0] frame_idx = '0;
  logic [NP-1:0] port_owner = '0, port_conn = '0;
  logic [NP-1:0] port_csc = '0, port_pec = '0, port_occ = '0, port_fpr = '0;
  logic          wake_load = 1'b0, wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [2:0]    int_en = '0;
  logic [31:0]   status;
  logic          run_stop_clr, irq;

  int checks = 0;
  int failures = 0;

  usb_host_event_status #(.NPORTS(NP), .FRAME_W(FW), .ROLL_BIT(13)) u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_cmp_valid(rd_cmp_valid), .rd_cmp_ok(rd_cmp_ok),
    .frame_idx(frame_idx), .port_owner(port_owner), .port_conn(port_conn),
    .port_csc(port_csc), .port_pec(port_pec), .port_occ(port_occ),
    .port_fpr(port_fpr), .wake_load(wake_load),
    .wr_en(wr_en), .wr_data(wr_data), .int_en(int_en),
    .status(status), .run_stop_clr(run_stop_clr), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    wr_en = 1'b1; wr_data = 32'h0000_001C;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset();
    chk("R1 status", status, 32'h0000_1000);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 run_stop_clr", {31'b0, run_stop_clr}, 0);
  endtask

  task automatic t_host_err();
    rd_cmp_valid = 1'b1; rd_cmp_ok = 1'b1;
    step(1);
    chk("R2 ok completion", {31'b0, status[4]}, 0);
    chk("R3 no request on ok", {31'b0, run_stop_clr}, 0);
    rd_cmp_ok = 1'b0;
    step(1);
    rd_cmp_valid = 1'b0;
    chk("R2 failed completion", {31'b0, status[4]}, 1);
    chk("R3 request pulse", {31'b0, run_stop_clr}, 1);
    step(1);
    chk("R3 pulse ends", {31'b0, run_stop_clr}, 0);
    chk("R2 bit held", {31'b0, status[4]}, 1);
  endtask

  task automatic t_w1c();
    wr_en = 1'b1; wr_data = 32'h0;
    step(1);
    chk("R4 zero write keeps", {31'b0, status[4]}, 1);
    wr_data = 32'hFFFF_FFFF;
    step(1);
    wr_en = 1'b0; wr_data = '0;
    chk("R4 all-ones write", status, 32'h0000_1000);
  endtask

  task automatic t_set_wins();
    rd_cmp_valid = 1'b1; rd_cmp_ok = 1'b0;
    wr_en = 1'b1; wr_data = 32'h10;
    step(1);
    rd_cmp_valid = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R5 set beats clear", {31'b0, status[4]}, 1);
    step(1);
    clear_all();
  endtask

  task automatic t_rollover();
    frame_idx = 14'h1FFF;
    step(1);
    chk("R6 low bits only", {31'b0, status[3]}, 0);
    frame_idx = 14'h2000;
    step(1);
    chk("R6 rise of bit 13", {31'b0, status[3]}, 1);
    clear_all();
    chk("R6 cleared", {31'b0, status[3]}, 0);
    frame_idx = 14'h0000;
    step(1);
    chk("R6 fall of bit 13", {31'b0, status[3]}, 1);
    clear_all();
  endtask

  task automatic t_port_edges();
    port_csc[0] = 1'b1;
    step(1);
    chk("R7 csc edge", {31'b0, status[2]}, 1);
    clear_all();
    step(2);
    chk("R7 held level once", {31'b0, status[2]}, 0);
    port_csc[0] = 1'b0;
    step(1);
    port_fpr[2] = 1'b1;
    step(1);
    chk("R7 resume edge last port", {31'b0, status[2]}, 1);
    clear_all();
    port_fpr[2] = 1'b0;
    port_owner[1] = 1'b1;
    step(1);
    port_occ[1] = 1'b1;
    port_pec[1] = 1'b1;
    step(2);
    chk("R8 foreign port ignored", {31'b0, status[2]}, 0);
    port_occ[1] = 1'b0; port_pec[1] = 1'b0;
    step(1);
  endtask

  task automatic t_handover();
    port_conn[1] = 1'b1; port_csc[1] = 1'b1;
    step(2);
    chk("R9 before handover", {31'b0, status[2]}, 0);
    port_owner[1] = 1'b0;
    step(1);
    chk("R9 first edge", {31'b0, status[2]}, 0);
    step(1);
    chk("R9 handover report", {31'b0, status[2]}, 1);
    clear_all();
    step(2);
    chk("R9 reports once", {31'b0, status[2]}, 0);
    port_csc[1] = 1'b0; port_conn[1] = 1'b0;
    step(1);
  endtask

  task automatic t_wake();
    port_owner[2] = 1'b1;
    step(1);
    port_pec[2] = 1'b1;
    step(2);
    chk("R10 before wake", {31'b0, status[2]}, 0);
    wake_load = 1'b1;
    step(1);
    wake_load = 1'b0;
    chk("R10 load one", {31'b0, status[2]}, 1);
    port_pec[2] = 1'b0; port_owner[2] = 1'b0;
    step(1);
    wake_load = 1'b1;
    step(1);
    wake_load = 1'b0;
    chk("R10 load zero", {31'b0, status[2]}, 0);
  endtask

  task automatic t_irq();
    int_en = 3'b000;
    rd_cmp_valid = 1'b1; rd_cmp_ok = 1'b0;
    step(1);
    rd_cmp_valid = 1'b0;
    step(1);
    chk("R11 disabled", {31'b0, irq}, 0);
    int_en = 3'b100;
    step(1);
    chk("R11 enabled error", {31'b0, irq}, 1);
    clear_all();
    step(1);
    chk("R11 drops after clear", {31'b0, irq}, 0);
    int_en = 3'b010;
    frame_idx = 14'h2000;
    step(2);
    chk("R11 rollover enable", {31'b0, irq}, 1);
    int_en = 3'b001;
    step(1);
    chk("R11 other enable only", {31'b0, irq}, 0);
    clear_all();
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_host_err();
    t_w1c();
    t_set_wins();
    t_rollover();
    t_port_edges();
    t_handover();
    t_wake();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule